// File: doc/BRIEF.md
# Next Fetch Address Unit

This block owns the program counter of a 32-bit load/store core with fixed-width instructions. Each clock edge it loads a new fetch address. It picks that address from four candidates: the word that follows, a conditional branch target relative to the incremented address, a region-local absolute jump target, or a target held in a register. The current counter drives the instruction memory address. The incremented value is also an output, so that a call instruction can write its return address.

The unit looks only at the control-flow fields of the word being fetched: the 6-bit major opcode, the 6-bit function code of register-format words, the 16-bit offset and the 26-bit jump index. The surrounding pipeline supplies the two register values to compare for a branch and the register value to use for a register jump. Hazard detection drives a stall input that freezes the counter.

Top module: `pc_next_unit`

## Requirements
- R1: A synchronous active-high `rst` loads `pc` with 0 on the next rising edge. It takes priority over `stall` and over any instruction.
- R2: When no transfer applies, `pc` advances by 4 per edge and wraps modulo 2^32. `pc_plus4` always equals `pc` + 4.
- R3: Opcode 6'h04 (bits 31:26) is a branch-if-equal. When `op_a` equals `op_b`, the next `pc` is `pc`+4 plus the sign-extended bits 15:0 times 4. Otherwise the next `pc` is `pc`+4.
- R4: Opcode 6'h05 is a branch-if-not-equal. It takes the same target as R3, but only when `op_a` differs from `op_b`.
- R5: Opcodes 6'h02 (jump) and 6'h03 (jump-and-link) load bits 31:28 of `pc`+4, then bits 25:0 of the instruction, then two zero bits.
- R6: Opcode 6'h00 with function bits 5:0 equal to 6'h08 is a register jump. It loads `jr_val` with its two low bits cleared.
- R7: While `stall` is high and `rst` is low, `pc` keeps its value, even when the instruction is a taken transfer.
- R8: Every other opcode, and every register-format function code other than 6'h08, advances sequentially.
- R9: Bits 1:0 of `pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freezes the program counter |
| instr | input | 32 | Instruction fetched at the current `pc` |
| op_a | input | 32 | First branch comparison operand |
| op_b | input | 32 | Second branch comparison operand |
| jr_val | input | 32 | Register-jump target value |
| pc | output | 32 | Current fetch address |
| pc_plus4 | output | 32 | `pc` + 4, for link writes |

## Verification
Each conditional branch is driven with equal and with unequal operands. This separates the two branch senses from each other and from a plain sequential step. Forward and backward offsets expose sign-extension errors. A jump issued at address 0x0FFFFFFC shows whether the upper bits come from `pc`+4 or from `pc`. A register target with its low bits set exercises the alignment mask. A jump held under stall, a reset raised together with stall, and undefined opcodes whose branch operands compare equal check the priority order and the fall-back to sequential.

// File: rtl/pc_next_pkg.sv
package pc_next_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned IDX_W   = 26;
  localparam int unsigned REGION_W = AW - IDX_W - 2;
  localparam logic [AW-1:0] STEP  = AW'(4);

  localparam logic [OPC_W-1:0] OPC_RFMT = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_CALL = 6'h03;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'h05;
  localparam logic [FN_W-1:0]  FN_RJMP  = 6'h08;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JMP  = 2'd2,
    SEL_RJMP = 2'd3
  } nxt_sel_e;

  // Branch target: incremented address plus word-scaled signed offset
  function automatic logic [AW-1:0] br_target(input logic [AW-1:0] pc4,
                                              input logic [OFF_W-1:0] off);
    return pc4 + {{(AW-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
  endfunction

  // Region jump: keep the top bits of the incremented address
  function automatic logic [AW-1:0] jmp_target(input logic [AW-1:0] pc4,
                                               input logic [IDX_W-1:0] idx);
    return {pc4[AW-1 -: REGION_W], idx, 2'b00};
  endfunction

  function automatic logic [AW-1:0] word_align(input logic [AW-1:0] v);
    return {v[AW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/pc_next_decode.sv
module pc_next_decode
  import pc_next_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  fn,
  input  logic [AW-1:0]    op_a,
  input  logic [AW-1:0]    op_b,
  output nxt_sel_e         sel
);
  logic ops_equal;
  assign ops_equal = (op_a == op_b);

  always_comb begin
    sel = SEL_SEQ;
    unique case (opc)
      OPC_BEQ:  if (ops_equal)  sel = SEL_BR;
      OPC_BNE:  if (!ops_equal) sel = SEL_BR;
      OPC_JMP,
      OPC_CALL: sel = SEL_JMP;
      OPC_RFMT: if (fn == FN_RJMP) sel = SEL_RJMP;
      default:  sel = SEL_SEQ;
    endcase
  end
endmodule

// File: rtl/pc_next_target.sv
module pc_next_target
  import pc_next_pkg::*;
(
  input  logic [AW-1:0]    pc,
  input  logic [IDX_W-1:0] field,
  input  logic [AW-1:0]    jr_val,
  input  nxt_sel_e         sel,
  output logic [AW-1:0]    pc4,
  output logic [AW-1:0]    nxt
);
  assign pc4 = pc + STEP;

  always_comb begin
    unique case (sel)
      SEL_BR:   nxt = br_target(pc4, field[OFF_W-1:0]);
      SEL_JMP:  nxt = jmp_target(pc4, field);
      SEL_RJMP: nxt = word_align(jr_val);
      default:  nxt = pc4;
    endcase
  end
endmodule

// File: rtl/pc_next_reg.sv
module pc_next_reg
  import pc_next_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_PC;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pc_next_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [31:0] jr_val,
  output logic [31:0] pc,
  output logic [31:0] pc_plus4
);
  nxt_sel_e      sel;
  logic [AW-1:0] nxt;
  // Named events for the checker
  logic          seq_sel;
  logic          xfer_taken;

  assign seq_sel    = (sel == SEL_SEQ);
  assign xfer_taken = !seq_sel;

  pc_next_decode u_dec (
    .opc  (instr[AW-1 -: OPC_W]),
    .fn   (instr[FN_W-1:0]),
    .op_a (op_a),
    .op_b (op_b),
    .sel  (sel)
  );

  pc_next_target u_tgt (
    .pc     (pc),
    .field  (instr[IDX_W-1:0]),
    .jr_val (jr_val),
    .sel    (sel),
    .pc4    (pc_plus4),
    .nxt    (nxt)
  );

  pc_next_reg #(.RESET_PC(word_align(RESET_PC))) u_reg (
    .clk  (clk),
    .rst  (rst),
    .hold (stall),
    .d    (nxt),
    .q    (pc)
  );
endmodule

// File: rtl/pc_next_unit_chk.sv
module pc_next_unit_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic [31:0] instr,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic [31:0] jr_val,
  input logic [31:0] pc,
  input logic        seq_sel,
  input logic        xfer_taken
);
  // R1
  reset_load_chk: assert property (@(posedge clk) rst |=> pc == {RESET_PC[31:2], 2'b00});

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> pc == $past(pc));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && seq_sel) |=> pc == $past(pc) + 32'd4);

  // R3
  beq_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && instr[31:26] == 6'h04 && op_a == op_b)
    |=> pc == $past(pc) + 32'd4 + ($past({{16{instr[15]}}, instr[15:0]}) << 2));

  // R4
  bne_hold_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'h05 && op_a == op_b) |-> seq_sel);

  // R5
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && (instr[31:26] == 6'h02 || instr[31:26] == 6'h03))
    |=> pc[31:28] == $past(pc + 32'd4) >> 28 && pc[27:2] == $past(instr[25:0]));

  // R6
  rjump_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && instr[31:26] == 6'h00 && instr[5:0] == 6'h08)
    |=> pc == {$past(jr_val[31:2]), 2'b00});

  // R8
  undef_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] > 6'h05 || instr[31:26] == 6'h01) |-> !xfer_taken);

  // R9
  align_chk: assert property (@(posedge clk) disable iff (rst) pc[1:0] == 2'b00);
endmodule

bind pc_next_unit pc_next_unit_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall      (stall),
  .instr      (instr),
  .op_a       (op_a),
  .op_b       (op_b),
  .jr_val     (jr_val),
  .pc         (pc),
  .seq_sel    (seq_sel),
  .xfer_taken (xfer_taken)
);

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [31:0] op_a = 32'h0;
  logic [31:0] op_b = 32'h0;
  logic [31:0] jr_val = 32'h0;
  logic [31:0] pc;
  logic [31:0] pc_plus4;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] m_pc = 32'h0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pc_next_unit u_pc_next_unit (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .op_a(op_a), .op_b(op_b), .jr_val(jr_val),
    .pc(pc), .pc_plus4(pc_plus4)
  );

  function automatic logic [31:0] mk_i(input logic [5:0] op, input int off);
    logic [15:0] o16;
    o16 = 16'(off);
    return {op, 5'd1, 5'd2, o16};
  endfunction

  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  function automatic logic [31:0] mk_r(input logic [5:0] fn);
    return {6'h00, 5'd3, 5'd4, 5'd5, 5'd0, fn};
  endfunction

  // Reference next address written from the requirement text
  function automatic logic [31:0] model(input logic [31:0] p, input bit r, input bit s,
                                        input logic [31:0] w, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] j);
    int off;
    logic [31:0] inc;
    inc = p + 32'd4;
    off = int'(w[15:0]);
    if (off > 32767) off = off - 65536;
    if (r) return 32'h0;
    if (s) return p;
    case (w[31:26])
      6'h04: return (a == b) ? inc + 32'(off * 4) : inc;
      6'h05: return (a != b) ? inc + 32'(off * 4) : inc;
      6'h02, 6'h03: return (inc & 32'hF000_0000) | (32'(w[25:0]) * 4);
      6'h00: return (w[5:0] == 6'h08) ? (j & 32'hFFFF_FFFC) : inc;
      default: return inc;
    endcase
  endfunction

  task automatic step(input bit r, input bit s, input logic [31:0] w,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] j, input string tag);
    @(negedge clk);
    rst = r; stall = s; instr = w; op_a = a; op_b = b; jr_val = j;
    m_pc = model(m_pc, r, s, w, a, b, j);
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare once the edge has loaded the register
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(pc, e, t);
      check(pc_plus4, e + 32'd4, "R2 pc_plus4");
      check({30'h0, pc[1:0]}, 32'h0, "R9 alignment");
    end
  end

  initial begin
    step(1, 1, mk_j(6'h02, 26'h55), 0, 0, 0, "R1 reset over stall");
    step(1, 0, 32'h0, 0, 0, 0, "R1 reset");
    step(0, 0, mk_r(6'h20), 0, 0, 0, "R2 sequential 4");
    step(0, 0, mk_r(6'h20), 0, 0, 0, "R2 sequential 8");
    step(0, 0, mk_i(6'h04, 3), 32'h11, 32'h11, 0, "R3 beq taken fwd");
    step(0, 0, mk_i(6'h04, 3), 32'h11, 32'h12, 0, "R3 beq not taken");
    step(0, 0, mk_i(6'h05, -2), 32'h5, 32'h6, 0, "R4 bne taken back");
    step(0, 0, mk_i(6'h05, -2), 32'h7, 32'h7, 0, "R4 bne not taken");
    step(0, 0, mk_i(6'h04, -1), 32'h0, 32'h0, 0, "R3 beq offset -1");
    step(0, 0, mk_j(6'h02, 26'h40), 0, 0, 0, "R5 jump");
    step(0, 0, mk_j(6'h03, 26'h3FF_FFFF), 0, 0, 0, "R5 jump-and-link");
    step(0, 1, mk_j(6'h02, 26'h10), 0, 0, 0, "R7 stall over jump");
    step(0, 1, mk_i(6'h04, 9), 1, 1, 0, "R7 stall over branch");
    step(0, 0, mk_j(6'h02, 26'h10), 0, 0, 0, "R5 region from pc+4");
    step(0, 0, mk_r(6'h08), 0, 0, 32'h0000_2003, "R6 register jump");
    step(0, 0, mk_r(6'h20), 0, 0, 32'h0000_9000, "R8 other function");
    step(0, 0, mk_i(6'h3F, 5), 32'h4, 32'h4, 0, "R8 undefined opcode");
    step(0, 0, mk_i(6'h06, 5), 32'h4, 32'h4, 0, "R8 opcode 6");
    step(0, 1, mk_r(6'h08), 0, 0, 32'h0000_4000, "R7 stall over register jump");
    step(0, 0, mk_r(6'h08), 0, 0, 32'hFFFF_FFFF, "R6 register jump mask");
    step(0, 0, mk_r(6'h00), 0, 0, 0, "R2 wrap to zero");
    step(0, 0, mk_r(6'h00), 0, 0, 0, "R2 after wrap");
    step(1, 0, mk_r(6'h08), 0, 0, 32'h100, "R1 reset mid-run");
    step(0, 0, mk_r(6'h00), 0, 0, 0, "R2 after reset");
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 2000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=2000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule